// File: doc/BRIEF.md
# Linked-Descriptor Read DMA Engine

This engine walks a chain of descriptors held in memory and copies each descriptor's data buffer, one word at a time, into a downstream FIFO. Software writes the address of the first descriptor through a small register port. The engine then fetches that four-word descriptor and streams its buffer. After that it follows the link word to the next descriptor, until it reaches a descriptor marked as the end of the list. Descriptors in memory are never written back. Software learns about progress from two sticky interrupt bits and from a packet-head register.

A packet is a run of descriptors that ends with one whose end-of-packet bit is set. The end-of-packet condition travels to the consumer as a sideband flag on the last data word of that descriptor, so a downstream channel can stop on it. Each descriptor carries a wait bit. With the bit set, completion is delayed until the FIFO has emptied. With the bit clear, completion is reported as soon as the last word has been read from memory, and the next descriptor is fetched at once.

Top module: `dchain_rd_engine`

## Requirements
- R1: After reset, no memory request and no FIFO write are active, both interrupt outputs are 0, and the status and packet-head reads return 0.
- R2: A descriptor is four consecutive words at its word address: control (bit0 end-of-packet, bit1 interrupt request, bit2 wait, bit3 end-of-list), length in words (low 16 bits), buffer word address, next-descriptor address. Each descriptor takes exactly four descriptor reads plus one read per buffer word, and at most one read is outstanding at any time.
- R3: Buffer words are written to the FIFO in ascending address order, and each write carries the word the memory returned.
- R4: The end-of-packet sideband is 1 only on the last word of a descriptor whose end-of-packet bit is set.
- R5: When a descriptor completes, the descriptor-done interrupt is set only if its interrupt-request bit is set, and the end-of-packet interrupt is set only if its end-of-packet bit is set.
- R6: With the wait bit set, a descriptor completes only after the FIFO reports empty. While the FIFO still holds data, the engine stays busy and both interrupts stay clear.
- R7: With the wait bit clear, a descriptor completes without regard to FIFO occupancy, once its last word has been read.
- R8: Register address 0 reads the packet-head register. A start loads it with the start address. Completion of an end-of-packet descriptor loads it with the next-descriptor address, or with 0 if that descriptor was also end-of-list. Completion of any other descriptor leaves it unchanged.
- R9: After a descriptor completes, the engine fetches the descriptor at its next address, unless the descriptor is end-of-list, in which case the engine goes idle (status bit2 busy = 0).
- R10: Register address 1 reads status (bit0 descriptor-done, bit1 end-of-packet, bit2 busy). Writing 1 to bit0 or bit1 at address 1 clears only that interrupt bit.
- R11: No buffer read is issued while the FIFO reports full, so the FIFO is never written while full.
- R12: A write to address 0 while the engine is busy is ignored. It neither restarts the engine nor changes the packet-head register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 start/head, 1 status/clear |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after the address |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write data |
| fifo_weop | output | 1 | End-of-packet sideband on the written word |
| fifo_full | input | 1 | FIFO has no free entry |
| fifo_empty | input | 1 | FIFO holds no data |
| irq_desc | output | 1 | Sticky descriptor-done interrupt |
| irq_eop | output | 1 | Sticky end-of-packet interrupt |

## Verification
A single end-of-list descriptor with a free-running drain checks the basic word stream and the exact count of memory reads. The same descriptor shape is then run with the drain held off, once with the wait bit set and once with it clear. The FIFO occupancy at the moment the interrupt rises tells held-back completion apart from early completion. A long buffer with the drain held off checks that the engine stops at the FIFO's capacity. A three-descriptor, two-packet chain, stalled on full in its final descriptor, shows the packet-head pointer stepping to the following packet. It also shows that a start written mid-chain is ignored and that the end-of-packet flag marks packet boundaries only. An end-of-list descriptor without end-of-packet checks that the head pointer is left unchanged.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DATA,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;

  // descriptor layout: word offsets within a descriptor
  localparam int DESC_WORDS = 4;
  localparam int DW_CTRL    = 0;
  localparam int DW_LEN     = 1;
  localparam int DW_BUF     = 2;
  localparam int DW_NEXT    = 3;

  // control word bit positions
  localparam int CB_EOP  = 0;
  localparam int CB_INTR = 1;
  localparam int CB_WAIT = 2;
  localparam int CB_LAST = 3;

  // register select values
  localparam logic RA_HEAD = 1'b0;
  localparam logic RA_STAT = 1'b1;

  // status bit positions
  localparam int SB_DESC = 0;
  localparam int SB_EOP  = 1;
  localparam int SB_BUSY = 2;

endpackage

// File: rtl/dchain_rdport.sv
module dchain_rdport #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic pending;

  // only a response to an outstanding request is passed on
  assign rsp_valid = mem_rvalid && pending;
  assign rsp_data  = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      pending  <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      if (issue && !pending) begin
        mem_req  <= 1'b1;
        mem_addr <= issue_addr;
        pending  <= 1'b1;
      end else if (mem_rvalid) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic [AW-1:0] start_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  output logic          issue,
  output logic [AW-1:0] issue_addr,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_weop,
  output logic          set_desc,
  output logic          set_eop,
  output logic          head_upd,
  output logic [AW-1:0] head_val,
  output logic          idle
);

  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  seq_state_e    st;
  logic [AW-1:0] cur;
  logic [AW-1:0] buf_base;
  logic [AW-1:0] nxt;
  logic [IW-1:0] widx;
  logic [LW-1:0] len;
  logic [LW-1:0] rcnt;
  logic          f_eop, f_intr, f_wait, f_last;
  logic          last_beat;

  assign last_beat = (rcnt == len - LW'(1));

  // read request selection
  always_comb begin
    issue      = 1'b0;
    issue_addr = cur + AW'(widx);
    case (st)
      ST_FETCH: issue = 1'b1;
      ST_DATA: begin
        issue      = (rcnt < len) && !fifo_full && !fifo_wr_en;
        issue_addr = buf_base + AW'(rcnt);
      end
      default: ;
    endcase
  end

  // completion effects, registered in the register block
  assign set_desc = (st == ST_DONE) && f_intr;
  assign set_eop  = (st == ST_DONE) && f_eop;
  assign head_upd = (st == ST_DONE) && f_eop;
  assign head_val = f_last ? '0 : nxt;
  assign idle     = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= '0;
      buf_base   <= '0;
      nxt        <= '0;
      widx       <= '0;
      len        <= '0;
      rcnt       <= '0;
      f_eop      <= 1'b0;
      f_intr     <= 1'b0;
      f_wait     <= 1'b0;
      f_last     <= 1'b0;
      fifo_wr_en <= 1'b0;
      fifo_wdata <= '0;
      fifo_weop  <= 1'b0;
    end else begin
      fifo_wr_en <= 1'b0;
      fifo_weop  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_go) begin
            cur  <= start_addr;
            widx <= '0;
            st   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rsp_valid) begin
            if (widx == IW'(DW_CTRL)) begin
              f_eop  <= rsp_data[CB_EOP];
              f_intr <= rsp_data[CB_INTR];
              f_wait <= rsp_data[CB_WAIT];
              f_last <= rsp_data[CB_LAST];
            end
            if (widx == IW'(DW_LEN))  len      <= rsp_data[LW-1:0];
            if (widx == IW'(DW_BUF))  buf_base <= rsp_data[AW-1:0];
            if (widx == IW'(DW_NEXT)) nxt      <= rsp_data[AW-1:0];
            widx <= widx + 1'b1;
            if (widx == LAST_IDX) begin
              rcnt <= '0;
              if (len != '0)   st <= ST_DATA;
              else if (f_wait) st <= ST_DRAIN;
              else             st <= ST_DONE;
            end
          end
        end
        ST_DATA: begin
          if (rsp_valid) begin
            fifo_wr_en <= 1'b1;
            fifo_wdata <= rsp_data;
            fifo_weop  <= f_eop && last_beat;
            rcnt       <= rcnt + LW'(1);
            if (last_beat) st <= f_wait ? ST_DRAIN : ST_DONE;
          end
        end
        ST_DRAIN: begin
          if (fifo_empty && !fifo_wr_en) st <= ST_DONE;
        end
        ST_DONE: begin
          if (f_last) begin
            st <= ST_IDLE;
          end else begin
            cur  <= nxt;
            widx <= '0;
            st   <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dchain_regs.sv
module dchain_regs
  import dchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          idle,
  input  logic          set_desc,
  input  logic          set_eop,
  input  logic          head_upd,
  input  logic [AW-1:0] head_val,
  output logic          start_go,
  output logic [AW-1:0] start_addr,
  output logic          irq_desc,
  output logic          irq_eop
);

  logic [AW-1:0] head;
  logic          clr_wr;
  logic [DW-1:0] stat_word;
  wire           unused_wdata = ^reg_wdata[DW-1:AW];

  assign start_go   = reg_wr && (reg_addr == RA_HEAD) && idle;
  assign start_addr = reg_wdata[AW-1:0];
  assign clr_wr     = reg_wr && (reg_addr == RA_STAT);

  always_comb begin
    stat_word          = '0;
    stat_word[SB_DESC] = irq_desc;
    stat_word[SB_EOP]  = irq_eop;
    stat_word[SB_BUSY] = !idle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      irq_desc  <= 1'b0;
      irq_eop   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (start_go)      head <= start_addr;
      else if (head_upd) head <= head_val;
      // a set in the same cycle as a clear wins
      irq_desc  <= set_desc | (irq_desc & ~(clr_wr & reg_wdata[SB_DESC]));
      irq_eop   <= set_eop  | (irq_eop  & ~(clr_wr & reg_wdata[SB_EOP]));
      reg_rdata <= (reg_addr == RA_STAT) ? stat_word : DW'(head);
    end
  end

endmodule

// File: rtl/dchain_rd_engine.sv
module dchain_rd_engine
  import dchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_weop,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  output logic          irq_desc,
  output logic          irq_eop
);

  logic          start_go;
  logic [AW-1:0] start_addr;
  logic          issue;
  logic [AW-1:0] issue_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          set_desc, set_eop, head_upd, idle;
  logic [AW-1:0] head_val;

  dchain_rdport #(.AW(AW), .DW(DW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_addr(issue_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  dchain_seq #(.AW(AW), .DW(DW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_go  (start_go),
    .start_addr(start_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .issue     (issue),
    .issue_addr(issue_addr),
    .fifo_wr_en(fifo_wr_en),
    .fifo_wdata(fifo_wdata),
    .fifo_weop (fifo_weop),
    .set_desc  (set_desc),
    .set_eop   (set_eop),
    .head_upd  (head_upd),
    .head_val  (head_val),
    .idle      (idle)
  );

  dchain_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .idle      (idle),
    .set_desc  (set_desc),
    .set_eop   (set_eop),
    .head_upd  (head_upd),
    .head_val  (head_val),
    .start_go  (start_go),
    .start_addr(start_addr),
    .irq_desc  (irq_desc),
    .irq_eop   (irq_eop)
  );

endmodule

// File: rtl/dchain_chk.sv
module dchain_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          fifo_wr_en,
  input logic          fifo_weop,
  input logic          fifo_full,
  input logic          irq_desc,
  input logic          irq_eop
);

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3
  write_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> $past(mem_rvalid));

  // R4
  eop_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_weop |-> fifo_wr_en);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> !$past(fifo_full));

  // R10
  desc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_desc) |-> $past(reg_wr && reg_addr && reg_wdata[0]));

  // R10
  eop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_eop) |-> $past(reg_wr && reg_addr && reg_wdata[1]));

endmodule

bind dchain_rd_engine dchain_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_rvalid(mem_rvalid),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .fifo_wr_en(fifo_wr_en),
  .fifo_weop (fifo_weop),
  .fifo_full (fifo_full),
  .irq_desc  (irq_desc),
  .irq_eop   (irq_eop)
);

// File: tb/dchain_rd_engine_test.sv
`timescale 1ns/1ps
module dchain_rd_engine_test;

  localparam int FDEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fifo_wr_en;
  logic [31:0] fifo_wdata;
  logic        fifo_weop;
  logic        fifo_full = 1'b0;
  logic        fifo_empty = 1'b1;
  logic        irq_desc, irq_eop;

  logic [31:0] mem [0:255];
  logic [32:0] exp_q [$];
  int          vectors = 0, miscompares = 0;
  int          occ = 0, push_cnt = 0, req_cnt = 0, rise_occ = 0;
  bit          drain_en = 1'b1, rise_seen = 1'b0, finished = 1'b0;
  logic        prev_irq = 1'b0;

  always #2 clk = ~clk;

  dchain_rd_engine uut (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_wr_en(fifo_wr_en), .fifo_wdata(fifo_wdata), .fifo_weop(fifo_weop),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .irq_desc(irq_desc), .irq_eop(irq_eop)
  );

  // memory, FIFO occupancy and write-stream reference, every clock
  always @(negedge clk) begin
    if (!rst) begin
      mem_rvalid = mem_req;
      if (mem_req) begin
        mem_rdata = mem[mem_addr[7:0]];
        req_cnt++;
      end
      if (fifo_wr_en) begin
        logic [32:0] e;
        push_cnt++;
        occ++;
        vectors++;
        if (exp_q.size() == 0) begin
          miscompares++;
          $display("FAIL R3 R4: got %h expected no write", {fifo_weop, fifo_wdata});
        end else begin
          e = exp_q.pop_front();
          if ({fifo_weop, fifo_wdata} !== e) begin
            miscompares++;
            $display("FAIL R3 R4: got %h expected %h", {fifo_weop, fifo_wdata}, e);
          end
        end
      end
      if (irq_desc && !prev_irq && !rise_seen) begin
        rise_seen = 1'b1;
        rise_occ  = occ;
      end
      prev_irq = irq_desc;
      if (drain_en && occ > 0) occ--;
      fifo_empty = (occ == 0);
      fifo_full  = (occ >= FDEPTH);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(1'b1, s);
      if (!s[2]) break;
    end
  endtask

  task automatic put_desc(input int a, input int ctrl, input int n, input int b, input int nx);
    mem[a]     = 32'(ctrl);
    mem[a + 1] = 32'(n);
    mem[a + 2] = 32'(b);
    mem[a + 3] = 32'(nx);
    for (int i = 0; i < n; i++) mem[(b + i) & 255] = 32'h5A000000 | 32'(b << 8) | 32'(i);
  endtask

  // walk the chain in bench memory to form the expected write stream
  task automatic build_exp(input int start);
    int a = start;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] c = mem[a & 255];
      int n = int'(mem[(a + 1) & 255]);
      int b = int'(mem[(a + 2) & 255]);
      for (int i = 0; i < n; i++)
        exp_q.push_back({(c[0] && (i == n - 1)), mem[(b + i) & 255]});
      if (c[3]) break;
      a = int'(mem[(a + 3) & 255]);
    end
  endtask

  task automatic launch(input int start);
    build_exp(start);
    wr(1'b0, 32'(start));
  endtask

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 fifo_wr_en", 32'(fifo_wr_en), 0);
    chk("R1 irq", 32'({irq_desc, irq_eop}), 0);
    rd(1'b1, s); chk("R1 status", s, 0);
    rd(1'b0, s); chk("R1 head", s, 0);

    // single descriptor, eop+intr+last, free drain
    put_desc(8'h10, 4'hB, 3, 8'h80, 0);
    req_cnt = 0;
    launch(8'h10);
    wait_idle();
    chk("R2 read count", 32'(req_cnt), 7);
    chk("R3 stream done", 32'(exp_q.size()), 0);
    rd(1'b1, s); chk("R5 status", s, 32'h3);
    rd(1'b0, s); chk("R8 head end of list", s, 0);
    chk("R5 irq pins", 32'({irq_eop, irq_desc}), 32'h3);
    wr(1'b1, 32'h3);

    // end-of-list without eop: head stays at start address
    put_desc(8'h20, 4'hA, 2, 8'h90, 0);
    launch(8'h20);
    wait_idle();
    rd(1'b0, s); chk("R8 head unchanged", s, 32'h20);
    rd(1'b1, s); chk("R5 intr only", s, 32'h1);
    chk("R9 idle after last", 32'(s[2]), 0);
    wr(1'b1, 32'h3);

    // wait bit set, drain stalled
    put_desc(8'h30, 4'hF, 3, 8'hA0, 0);
    drain_en = 1'b0; rise_seen = 1'b0;
    launch(8'h30);
    repeat (60) @(negedge clk);
    rd(1'b1, s); chk("R6 held while data remains", s, 32'h4);
    chk("R6 fifo occupancy", 32'(occ), 3);
    drain_en = 1'b1;
    wait_idle();
    chk("R6 irq seen", 32'(rise_seen), 1);
    chk("R6 fifo empty at irq", 32'(rise_occ), 0);
    rd(1'b1, s); chk("R6 final status", s, 32'h3);
    wr(1'b1, 32'h1);
    rd(1'b1, s); chk("R10 clear bit0 only", s, 32'h2);
    wr(1'b1, 32'h2);
    rd(1'b1, s); chk("R10 clear bit1", s, 32'h0);

    // wait bit clear, drain stalled
    put_desc(8'h40, 4'hB, 3, 8'hB0, 0);
    drain_en = 1'b0; rise_seen = 1'b0;
    launch(8'h40);
    repeat (60) @(negedge clk);
    chk("R7 irq seen", 32'(rise_seen), 1);
    chk("R7 fifo held data at irq", 32'(rise_occ), 3);
    rd(1'b1, s); chk("R7 done without drain", s, 32'h3);
    drain_en = 1'b1;
    repeat (10) @(negedge clk);
    wr(1'b1, 32'h3);

    // FIFO full backpressure
    put_desc(8'h50, 4'h9, 10, 8'hC0, 0);
    drain_en = 1'b0; push_cnt = 0;
    launch(8'h50);
    repeat (80) @(negedge clk);
    chk("R11 writes stop at capacity", 32'(push_cnt), FDEPTH);
    chk("R11 occupancy", 32'(occ), FDEPTH);
    drain_en = 1'b1;
    wait_idle();
    chk("R11 all words delivered", 32'(push_cnt), 10);
    rd(1'b1, s); chk("R5 no intr bit", s, 32'h2);
    wr(1'b1, 32'h3);

    // two-packet chain stalled in its last descriptor
    put_desc(8'h60, 4'h2, 2, 8'hD0, 8'h64);
    put_desc(8'h64, 4'h1, 2, 8'hD4, 8'h68);
    put_desc(8'h68, 4'hD, 2, 8'hD8, 0);
    drain_en = 1'b0;
    launch(8'h60);
    repeat (100) @(negedge clk);
    rd(1'b0, s); chk("R8 head at next packet", s, 32'h68);
    rd(1'b1, s); chk("R9 chain progress", s, 32'h7);
    wr(1'b0, 32'h10);
    rd(1'b0, s); chk("R12 head kept", s, 32'h68);
    drain_en = 1'b1;
    wait_idle();
    chk("R9 chain stream done", 32'(exp_q.size()), 0);
    rd(1'b0, s); chk("R8 head cleared", s, 0);
    push_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R12 no restart", 32'(push_cnt), 0);
    rd(1'b1, s); chk("R12 still idle", 32'(s[2]), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9 watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule